// File: doc/BRIEF.md
# Switchable Power Domain Power-Up Sequencer

This block brings a switchable power domain out of the off state. The domain holds a few modules, for example a signal-processing core and its accelerators. Software sets up the sequence through a small register bus. It asks for the domain to be on, chooses which modules should come up, and then writes a start command. The sequencer reports that it is busy and raises an external power request. That request tells the supply logic that the domain's rail switch has to be closed.

Software answers the request in two steps. First it writes an acknowledge to clear the pending request. Then it supplies a power-good indication, either as a register bit or on a dedicated input pin. Only after both steps does the sequencer release the selected modules, one per cycle in increasing index order. It then marks the domain as on, clears the low bits of the global control register and drops busy.

If software leaves the request unacknowledged for longer than a programmable number of cycles, a stall flag is set. Busy stays high and the sequence still waits; it does not give up.

Top module: `pd_powerup_seq`

## Requirements
- R1: After reset, busy_o, pwr_req_o, sw_close_o, dom_on_o and mod_en_o are all 0, and the timeout register (address 0xA) reads 100.
- R2: A write of data with bit 1 set to the command register (address 0x0) starts the sequence, provided domain control bit 0 (address 0x1) is set and the domain is off. busy_o and pwr_req_o go high on that same clock edge. The request also reads back as bit 1 of address 0x2, and busy reads back as bit 1 of address 0x5.
- R3: A start command has no effect if domain control bit 0 is clear, or if the command data has bit 1 clear.
- R4: The power request stays set until the acknowledge register (address 0x3) is written with bit 1 set; it clears on that edge. An acknowledge write with bit 1 clear is ignored.
- R5: After the acknowledge, the sequencer waits for power-good, which is domain control bit 8 OR the pwr_good_i pin. No module is enabled before power-good is seen, and busy stays high.
- R6: Module enables are driven on mod_en_o, and module i comes up only if bit i of the module-select register (address 0x8) is set. Let E be the first edge at which the sequencer sees power-good after the acknowledge. Module i is enabled on edge E+1+i, so modules come up in increasing index order, one per cycle. An enabled module stays enabled.
- R7: On the edge that handles the last module index, busy_o falls. On the same edge the domain status field (address 0x6, bits 4:0) becomes 0x1F, dom_on_o rises, and the global control field (address 0x7, bits 4:0) is cleared.
- R8: A start command given while the domain status field is nonzero is skipped: busy_o and pwr_req_o stay low.
- R9: While the request is pending, a cycle counter runs against the timeout register. Once more than that many cycles have elapsed, stall bit 2 of address 0x5 is set, busy stays high and the sequence keeps waiting. A later acknowledge still completes the sequence.
- R10: Writing 1 to bit 0 of the supply-switch register (address 0x4) drives sw_close_o high from the next edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | DW | Combinational read data |
| pwr_good_i | input | 1 | External power-good indication |
| pwr_req_o | output | 1 | External power request (pending) |
| sw_close_o | output | 1 | Supply switch close command |
| busy_o | output | 1 | Sequence in progress |
| dom_on_o | output | 1 | Domain is powered and on |
| mod_en_o | output | NMOD | Per-module reset release and clock enable |

## Verification
Register writes take effect on the edge that samples them. Busy and the request therefore rise on the start edge, and the request falls on the acknowledge edge. Module i follows at E+1+i, where E is the first edge with power-good in the waiting state, and completion lands on the same edge as the last module slot. The stall flag appears on the edge after the counter reaches the limit, which is the limit plus one edges after the start. The bench steps one edge at a time, samples 1 ns after each edge, and compares mod_en_o against the selected mask truncated to the indices processed so far. It sweeps all 16 module masks and alternates the source of power-good between the pin and the register bit.

// File: rtl/pd_powerup_seq.sv
module pd_powerup_seq #(
  parameter int NMOD   = 4,
  parameter int DW     = 16,
  parameter int AW     = 4,
  parameter int TO_RST = 100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  input  logic            pwr_good_i,
  output logic            pwr_req_o,
  output logic            sw_close_o,
  output logic            busy_o,
  output logic            dom_on_o,
  output logic [NMOD-1:0] mod_en_o
);
  localparam int IW = (NMOD > 1) ? $clog2(NMOD) : 1;
  localparam logic [AW-1:0] A_CMD  = AW'(0);
  localparam logic [AW-1:0] A_DCTL = AW'(1);
  localparam logic [AW-1:0] A_PEND = AW'(2);
  localparam logic [AW-1:0] A_ACK  = AW'(3);
  localparam logic [AW-1:0] A_SW   = AW'(4);
  localparam logic [AW-1:0] A_STAT = AW'(5);
  localparam logic [AW-1:0] A_DST  = AW'(6);
  localparam logic [AW-1:0] A_GBL  = AW'(7);
  localparam logic [AW-1:0] A_MSEL = AW'(8);
  localparam logic [AW-1:0] A_MST  = AW'(9);
  localparam logic [AW-1:0] A_TO   = AW'(10);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_PG, ST_MOD} st_t;

  st_t            state;
  logic           on_req, pg_sw, pend, stall;
  logic [4:0]     gbl, dstat;
  logic [NMOD-1:0] msel;
  logic [DW-1:0]  to_lim, to_cnt;
  logic [IW-1:0]  idx;

  wire go  = wr_en && wr_addr == A_CMD && wr_data[1];
  wire ack = wr_en && wr_addr == A_ACK && wr_data[1];
  wire pg  = pg_sw | pwr_good_i;
  wire last = (idx == IW'(NMOD-1));

  assign busy_o    = (state != ST_IDLE);
  assign pwr_req_o = pend;
  assign dom_on_o  = |dstat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      on_req     <= 1'b0;
      pg_sw      <= 1'b0;
      pend       <= 1'b0;
      stall      <= 1'b0;
      sw_close_o <= 1'b0;
      gbl        <= '0;
      dstat      <= '0;
      msel       <= '0;
      mod_en_o   <= '0;
      to_lim     <= DW'(TO_RST);
      to_cnt     <= '0;
      idx        <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_DCTL: begin on_req <= wr_data[0]; pg_sw <= wr_data[8]; end
          A_SW:   sw_close_o <= wr_data[0];
          A_GBL:  gbl <= wr_data[4:0];
          A_MSEL: msel <= wr_data[NMOD-1:0];
          A_TO:   to_lim <= wr_data;
          default: ;
        endcase
      end
      case (state)
        ST_IDLE: if (go && dstat == '0 && on_req) begin
          state  <= ST_REQ;
          pend   <= 1'b1;
          stall  <= 1'b0;
          to_cnt <= '0;
        end
        ST_REQ: begin
          if (ack) begin
            pend  <= 1'b0;
            state <= ST_PG;
          end else if (to_cnt == to_lim) begin
            stall <= 1'b1;
          end else begin
            to_cnt <= to_cnt + 1'b1;
          end
        end
        ST_PG: if (pg) begin
          state <= ST_MOD;
          idx   <= '0;
        end
        ST_MOD: begin
          if (msel[idx]) mod_en_o[idx] <= 1'b1;
          if (last) begin
            dstat <= 5'h1f;
            gbl   <= '0;
            state <= ST_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_DCTL: begin rd_data[0] = on_req; rd_data[8] = pg_sw; end
      A_PEND: rd_data[1] = pend;
      A_SW:   rd_data[0] = sw_close_o;
      A_STAT: begin rd_data[1] = busy_o; rd_data[2] = stall; end
      A_DST:  rd_data[4:0] = dstat;
      A_GBL:  rd_data[4:0] = gbl;
      A_MSEL: rd_data[NMOD-1:0] = msel;
      A_MST:  rd_data[NMOD-1:0] = mod_en_o;
      A_TO:   rd_data = to_lim;
      default: rd_data = '0;
    endcase
  end
endmodule

module pd_powerup_seq_chk #(
  parameter int NMOD = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy_o,
  input logic            pwr_req_o,
  input logic            dom_on_o,
  input logic [NMOD-1:0] mod_en_o
);
  a_r4_req_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_req_o |-> busy_o);
  a_r2_start_raises_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> pwr_req_o);
  a_r5_no_module_while_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en_o != $past(mod_en_o)) |-> !pwr_req_o);
  a_r6_one_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mod_en_o ^ $past(mod_en_o)) <= 1);
  a_r6_enables_stick: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en_o & $past(mod_en_o)) == $past(mod_en_o));
  a_r7_done_sets_on: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> dom_on_o);
  a_r8_no_restart_when_on: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_on_o && !busy_o) |=> !busy_o);
endmodule

bind pd_powerup_seq pd_powerup_seq_chk #(.NMOD(NMOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .pwr_req_o(pwr_req_o),
  .dom_on_o(dom_on_o), .mod_en_o(mod_en_o)
);

// File: tb/sim_pd_powerup_seq.sv
`timescale 1ns/1ps
module sim_pd_powerup_seq;
  localparam int NMOD = 4;
  localparam int DW = 16;
  localparam int AW = 4;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, pwr_good_i = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic pwr_req_o, sw_close_o, busy_o, dom_on_o;
  logic [NMOD-1:0] mod_en_o;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  pd_powerup_seq #(.NMOD(NMOD), .DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwr_good_i(pwr_good_i),
    .pwr_req_o(pwr_req_o), .sw_close_o(sw_close_o), .busy_o(busy_o),
    .dom_on_o(dom_on_o), .mod_en_o(mod_en_o));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    rd_addr = AW'(a); #1;
    d = int'(rd_data);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pwr_good_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v;
    for (int m = 0; m < (1 << NMOD); m++) begin
      do_reset();
      if (m == 0) begin
        chk("R1 busy", busy_o, 0);
        chk("R1 req", pwr_req_o, 0);
        chk("R1 sw", sw_close_o, 0);
        chk("R1 on", dom_on_o, 0);
        chk("R1 mod", mod_en_o, 0);
        rd(10, v); chk("R1 timeout", v, 100);
        wr(0, 2);  chk("R3 go without on request", busy_o, 0);
        wr(4, 1);  chk("R10 switch", sw_close_o, 1);
      end
      wr(1, 1);
      wr(8, m);
      wr(7, 5'h1f);
      wr(10, 5);
      if (m == 1) begin
        wr(0, 1); chk("R3 go data bit1 clear", busy_o, 0);
      end
      wr(0, 2);
      chk("R2 busy", busy_o, 1);
      chk("R2 req", pwr_req_o, 1);
      rd(2, v); chk("R2 pending readback", v, 2);
      rd(5, v); chk("R2 busy readback", v & 2, 2);
      if (m == 0) begin
        step(5); rd(5, v); chk("R9 no stall yet", v & 4, 0);
        step(1); rd(5, v); chk("R9 stall set", v & 4, 4);
        chk("R9 busy held", busy_o, 1);
        step(10); chk("R9 still waiting", pwr_req_o, 1);
      end else begin
        step(2);
      end
      wr(3, 1); chk("R4 ack without bit1", pwr_req_o, 1);
      wr(3, 2); chk("R4 ack clears", pwr_req_o, 0);
      chk("R5 busy after ack", busy_o, 1);
      step(3); chk("R5 no module before pg", mod_en_o, 0);
      chk("R5 still busy", busy_o, 1);
      if (m % 2 == 1) begin
        @(negedge clk); pwr_good_i = 1'b1;
      end else begin
        wr(1, 'h101);
      end
      step(1); chk("R6 none at edge E", mod_en_o, 0);
      for (int i = 0; i < NMOD; i++) begin
        step(1);
        chk("R6 module order", mod_en_o, m & ((1 << (i + 1)) - 1));
        chk("R7 busy timing", busy_o, (i == NMOD - 1) ? 0 : 1);
      end
      chk("R7 on", dom_on_o, 1);
      rd(6, v); chk("R7 status", v, 5'h1f);
      rd(7, v); chk("R7 global cleared", v, 0);
      wr(0, 2);
      chk("R8 skip busy", busy_o, 0);
      chk("R8 skip req", pwr_req_o, 0);
      chk("R6 enables held", mod_en_o, m);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule